// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block sequences synchronous burst reads from a word-addressed storage array that lives outside it. When chip enable is high and the address strobe is sampled with a starting address, the block waits through a programmable initial latency. It then presents one array read address per clock, taken from an internal counter that increments after each word. A data-valid strobe marks the cycles in which an address is presented.

The array is split into fixed blocks of 2^BLK_W words, 64 by default, starting at address 0. After the last word of a block has been presented, the block spends one extra cycle before moving to the next word. During that cycle data-valid is low and the ready output pulses low. When the counter runs past the top of the address space, it rolls over to address 0 and the burst carries on.

A burst continues until chip enable falls, reset is asserted, or the address strobe arrives with a new address. The initial latency comes from a 2-bit setting loaded through a small configuration write port. After reset that setting selects the longest latency.

Top module: `burst_rd_seq`

## Requirements
- R1: With chip enable high, a strobe sampled at rising edge E loads the start address. The first word appears just after edge E+N, where N = 4 + wait setting: rd_valid is high and rd_addr equals the start address. In the cycles between, rd_valid is low and rdy is high.
- R2: Within a block, every following edge presents the next address, one higher than the previous one, with rd_valid high.
- R3: When the presented address has its low BLK_W bits all ones (0x3F, 0x7F, ...), the next cycle has rd_valid low and rdy low. The cycle after that presents the address one higher.
- R4: rdy is low only in those boundary stall cycles. It stays high during the initial latency and while data flows, and every low pulse lasts exactly one cycle.
- R5: After the highest address (all ones), the counter rolls over to address 0 and the burst continues. The boundary stall of R3 also applies here.
- R6: Chip enable low at an edge ends the burst. After that edge rd_valid is low and rdy is high. A strobe sampled while chip enable is low starts nothing.
- R7: Synchronous reset (rst high) ends any burst and sets the wait setting to 3, which gives a latency of 7.
- R8: A strobe sampled during an active burst abandons it. The new start address loads at that edge, and the latency is counted again from that edge.
- R9: cfg_we high at an edge loads cfg_wait (0..3 gives a latency of 4..7) for later strobes. A strobe sampled at the same edge still uses the previous setting.
- R10: While no burst is active, rd_valid is low and rdy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Chip enable, active high |
| adv | input | 1 | Address strobe, active high |
| addr_in | input | AW | Burst start address |
| cfg_we | input | 1 | Write enable for the wait setting |
| cfg_wait | input | 2 | Wait setting, 0..3 gives a latency of 4..7 |
| rd_addr | output | AW | Array read address for the current word |
| rd_valid | output | 1 | rd_addr holds a word of the burst |
| rdy | output | 1 | Low for exactly one cycle at each boundary stall |

## Verification
The bench starts bursts just below a block end and just below the top of a reduced 8-bit address space. An off-by-one boundary test would either skip the stall or stall one word early, and a broken rollover would jump to the wrong address or lose the stall before address 0. It measures the initial latency for several wait settings, including a configuration write in the same cycle as a strobe. A miscounted wait state would move the first word by a cycle, and a bypassed setting register would apply the new value too soon. Re-strobing mid-burst, dropping chip enable, and strobing with chip enable low catch a sequencer that keeps running stale addresses or starts without being enabled.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_BURST = 2'd2,
    ST_STALL = 2'd3
  } bsr_state_e;

  localparam int unsigned LAT_BASE = 4;
endpackage

// File: rtl/bsr_cfg.sv
module bsr_cfg #(
  parameter int unsigned CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [CW-1:0] din,
  output logic [CW-1:0] q
);
  // reset value is the largest setting, i.e. the longest latency
  always_ff @(posedge clk) begin
    if (rst)     q <= '1;
    else if (we) q <= din;
  end
endmodule

// File: rtl/bsr_addr_ctr.sv
module bsr_addr_ctr #(
  parameter int unsigned AW = 21
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] cur
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  // natural AW-bit overflow provides the roll-over to zero
  always_ff @(posedge clk) begin
    if (rst)       cur <= '0;
    else if (load) cur <= load_val;
    else if (inc)  cur <= cur + ONE;
  end
endmodule

// File: rtl/bsr_fsm.sv
module bsr_fsm
  import bsr_pkg::*;
#(
  parameter int unsigned AW    = 21,
  parameter int unsigned BLK_W = 6,
  parameter int unsigned LW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          adv,
  input  logic [LW-1:0] lat_m1,
  input  logic [AW-1:0] cur_addr,
  output logic          ld,
  output logic          inc,
  output logic [AW-1:0] rd_addr,
  output logic          rd_valid,
  output logic          rdy
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  bsr_state_e    st;
  logic [LW-1:0] cnt;
  logic          blk_last;
  logic          go;

  assign blk_last = &rd_addr[BLK_W-1:0];
  assign go       = !rst && ce && !adv;
  assign ld       = !rst && ce && adv;
  assign inc      = go && ((st == ST_WAIT && cnt == '0) ||
                           (st == ST_BURST && !blk_last) ||
                           (st == ST_STALL));

  always_ff @(posedge clk) begin
    if (rst || !ce) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      rd_valid <= 1'b0;
      rdy      <= 1'b1;
      if (rst) rd_addr <= '0;
    end else if (adv) begin
      st       <= ST_WAIT;
      cnt      <= lat_m1;
      rd_valid <= 1'b0;
      rdy      <= 1'b1;
    end else begin
      case (st)
        ST_WAIT: begin
          if (cnt == '0) begin
            st       <= ST_BURST;
            rd_valid <= 1'b1;
            rd_addr  <= cur_addr;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_BURST: begin
          if (blk_last) begin
            st       <= ST_STALL;
            rd_valid <= 1'b0;
            rdy      <= 1'b0;
          end else begin
            rd_valid <= 1'b1;
            rd_addr  <= cur_addr;
          end
        end
        ST_STALL: begin
          st       <= ST_BURST;
          rd_valid <= 1'b1;
          rdy      <= 1'b1;
          rd_addr  <= cur_addr;
        end
        default: begin
          rd_valid <= 1'b0;
          rdy      <= 1'b1;
        end
      endcase
    end
  end

  // R2: inside a block, consecutive words step by one
  a_r2_step_by_one: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !blk_last && go) |=> (rd_valid && rd_addr == $past(rd_addr) + ONE));

  // R3: last word of a block is followed by one stall cycle
  a_r3_boundary_stall: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && blk_last && go) |=> (!rd_valid && !rdy));

  // R3: after the stall the next word appears
  a_r3_resume_after_stall: assert property (@(posedge clk) disable iff (rst)
    (!rdy && go) |=> (rd_valid && rdy));

  // R4: rdy never stays low for two cycles and never coincides with data
  a_r4_rdy_single_pulse: assert property (@(posedge clk) disable iff (rst)
    !rdy |=> rdy);
  a_r4_rdy_low_no_data: assert property (@(posedge clk) disable iff (rst)
    !rdy |-> !rd_valid);

  // R6: chip enable low ends the burst
  a_r6_ce_ends_burst: assert property (@(posedge clk) disable iff (rst)
    !ce |=> (!rd_valid && rdy));

  // R8: a strobe always restarts with a wait period
  a_r8_strobe_restarts: assert property (@(posedge clk) disable iff (rst)
    (ce && adv) |=> (!rd_valid && rdy && st == ST_WAIT));

  // R10: idle outputs
  a_r10_idle_outputs: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> (!rd_valid && rdy));
endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq
  import bsr_pkg::*;
#(
  parameter int unsigned AW    = 21,
  parameter int unsigned BLK_W = 6,
  parameter int unsigned CW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          adv,
  input  logic [AW-1:0] addr_in,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_wait,
  output logic [AW-1:0] rd_addr,
  output logic          rd_valid,
  output logic          rdy
);
  localparam int unsigned LW = $clog2(LAT_BASE + (1 << CW));

  logic [CW-1:0] cfg_q;
  logic [LW-1:0] lat_m1;
  logic [AW-1:0] cur_addr;
  logic          ld;
  logic          inc;

  assign lat_m1 = LW'(LAT_BASE - 1) + LW'(cfg_q);

  bsr_cfg #(.CW(CW)) u_cfg (
    .clk (clk),
    .rst (rst),
    .we  (cfg_we),
    .din (cfg_wait),
    .q   (cfg_q)
  );

  bsr_addr_ctr #(.AW(AW)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .load_val (addr_in),
    .inc      (inc),
    .cur      (cur_addr)
  );

  bsr_fsm #(.AW(AW), .BLK_W(BLK_W), .LW(LW)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .ce       (ce),
    .adv      (adv),
    .lat_m1   (lat_m1),
    .cur_addr (cur_addr),
    .ld       (ld),
    .inc      (inc),
    .rd_addr  (rd_addr),
    .rd_valid (rd_valid),
    .rdy      (rdy)
  );

  // R7: right after reset no burst is running
  a_r7_reset_idle: assert property (@(posedge clk)
    rst |=> (!rd_valid && rdy));
endmodule

// File: tb/test_burst_rd_seq.sv
module test_burst_rd_seq;
  localparam int AW   = 8;
  localparam int MASK = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce = 1'b1;
  logic          adv = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_wait = 2'd0;
  logic [AW-1:0] rd_addr;
  logic          rd_valid;
  logic          rdy;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  burst_rd_seq #(.AW(AW)) i_burst_rd_seq (
    .clk(clk), .rst(rst), .ce(ce), .adv(adv), .addr_in(addr_in),
    .cfg_we(cfg_we), .cfg_wait(cfg_wait),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rdy(rdy)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_quiet(input string req);
    chk(!rd_valid && rdy, req, {rd_valid, rdy}, 2'b01);
  endtask

  task automatic set_cfg(input logic [1:0] v);
    cfg_we = 1'b1; cfg_wait = v;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic strobe(input int a);
    adv = 1'b1; addr_in = AW'(a);
    tick();
    adv = 1'b0;
  endtask

  // after strobe(): checks latency lat, then nw words with boundary stalls
  task automatic run_burst(input int start, input int lat, input int nw, input string req);
    int exp_a;
    exp_a = start;
    for (int j = 1; j < lat; j++) begin
      tick();
      chk_quiet({req, " R1 wait"});
    end
    for (int i = 0; i < nw; i++) begin
      if (i > 0) begin
        if ((exp_a & 63) == 63) begin
          tick();
          chk(!rd_valid && !rdy, {req, " R3 stall"}, {rd_valid, rdy}, 2'b00);
        end
        exp_a = (exp_a + 1) & MASK;
      end
      tick();
      chk(rd_valid && rdy && int'(rd_addr) == exp_a, {req, " R2 word"}, int'(rd_addr), exp_a);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    chk_quiet("R7 R10 reset idle");
  endtask

  task automatic t_default_latency();
    strobe(8'h10);
    run_burst(8'h10, 7, 8, "R1 R7 default");
  endtask

  task automatic t_boundary();
    set_cfg(2'd0);
    strobe(8'h3D);
    run_burst(8'h3D, 4, 6, "R3 R4 boundary");
    strobe(8'h7F);
    run_burst(8'h7F, 4, 3, "R3 first word last");
  endtask

  task automatic t_wrap();
    set_cfg(2'd1);
    strobe(8'hFD);
    run_burst(8'hFD, 5, 6, "R5 wrap");
  endtask

  task automatic t_ce_end();
    set_cfg(2'd0);
    strobe(8'h20);
    run_burst(8'h20, 4, 3, "R6 pre");
    ce = 1'b0;
    tick();
    chk_quiet("R6 ce low ends");
    adv = 1'b1; addr_in = 8'h30;
    tick();
    adv = 1'b0;
    chk_quiet("R6 strobe ignored");
    ce = 1'b1;
    for (int k = 0; k < 8; k++) begin
      tick();
      chk_quiet("R6 R10 stays idle");
    end
  endtask

  task automatic t_restart();
    set_cfg(2'd2);
    strobe(8'h40);
    run_burst(8'h40, 6, 4, "R8 first");
    strobe(8'h90);
    run_burst(8'h90, 6, 4, "R8 restarted");
  endtask

  task automatic t_cfg_same_cycle();
    set_cfg(2'd0);
    cfg_we = 1'b1; cfg_wait = 2'd3;
    strobe(8'h05);
    cfg_we = 1'b0;
    run_burst(8'h05, 4, 2, "R9 old setting");
    strobe(8'h06);
    run_burst(8'h06, 7, 2, "R9 new setting");
  endtask

  task automatic t_reset_restores();
    set_cfg(2'd0);
    strobe(8'h50);
    tick();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk_quiet("R7 reset ends burst");
    strobe(8'h50);
    run_burst(8'h50, 7, 2, "R7 latency back to 7");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_default_latency();
    t_boundary();
    t_wrap();
    t_ce_end();
    t_restart();
    t_cfg_same_cycle();
    t_reset_restores();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule